// File: doc/BRIEF.md
# Serial EEPROM Page Write Sequencer

This block sits behind the serial-bus front-end of a small byte-addressed non-volatile memory. A write command first loads an 11-bit start address. The block then collects the incoming data bytes in a 16-entry page buffer and marks each slot it receives as valid. Nothing reaches the memory array until the front-end reports a Stop condition. If the front-end instead reports a repeated Start or an abort, the collected bytes are dropped.

Once Stop arrives with at least one byte buffered, the block runs a timed internal write cycle that lasts a fixed number of clock cycles. During the first sixteen cycles of that window it walks the page columns in ascending order. It drives one array write for every valid slot, unless the write-protect pin is high. For the whole window it holds a busy flag, which the front-end uses to refuse acknowledges.

Only the low four address bits advance between bytes, so a long burst wraps inside its page and overwrites earlier slots. When the cycle ends, the pointer shows the address just past the last byte received, still inside the same page. That pointer is where a following current-address read starts.

States: `ST_IDLE` (no command), `ST_FILL` (collecting bytes), `ST_PROG` (walking the sixteen columns) and `ST_SETTLE` (timing out the rest of the cycle). The transitions are:
- IDLE→FILL on an address load.
- FILL→IDLE on an abort, or on a Stop with an empty buffer.
- FILL→PROG on a Stop with at least one byte buffered.
- PROG→SETTLE after column 15.
- SETTLE→IDLE when the cycle counter reaches its limit.

Top module: `pgwr_sequencer`

## Requirements
- R1: After reset, `busy` and `mem_we` are 0 and `ptr_addr` is 0.
- R2: An address load in idle sets `ptr_addr` to the loaded value. Each data byte accepted afterwards adds 1 to bits [3:0] only, and bits [10:4] keep their value.
- R3: If more than 16 bytes arrive before Stop, the column wraps from 15 to 0. A later byte replaces the earlier byte in the same slot, and only the latest value is committed.
- R4: No array write happens before Stop. A Stop after at least one byte starts the write cycle. A Stop with no byte buffered, or a Stop in idle, starts none.
- R5: `busy` rises one clock after the Stop is sampled and stays high for exactly `WR_CYCLES` clocks. While it is high, address loads, data bytes and Stops are ignored.
- R6: In busy cycle k (k = 0..15, counted from the first busy cycle), `mem_we` is high exactly when column k was received. It then drives `mem_addr` = {page bits [10:4], k} with that slot's data. No other busy cycle writes.
- R7: While `wp` is high, `mem_we` stays 0 during the whole write cycle, and `busy` still lasts `WR_CYCLES` clocks.
- R8: An abort while collecting discards the buffered bytes and starts no write cycle. `ptr_addr` keeps its advanced value.
- R9: When `busy` falls, `ptr_addr` equals the last received address plus 1, wrapped within the page. All valid marks are cleared, so the next command writes only its own bytes.
- R10: Data bytes that arrive in idle, with no address loaded, are ignored and do not move `ptr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | One-cycle strobe: load start address |
| addr_in | input | ADDR_W | Start address for the write command |
| byte_stb | input | 1 | One-cycle strobe: data byte received |
| byte_in | input | DATA_W | Received data byte |
| stop_stb | input | 1 | One-cycle strobe: Stop condition seen |
| abort_stb | input | 1 | One-cycle strobe: repeated Start or abort |
| wp | input | 1 | Write-protect pin, high blocks all array writes |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| ptr_addr | output | ADDR_W | Current address pointer |

## Verification
- **Pointer:** a byte or address strobe sampled at one rising edge shows in `ptr_addr` after that edge.
- **Write cycle:** a Stop sampled at edge E raises `busy` after E. The write for column k appears between edges E+k and E+k+1, and `busy` is low again after edge E+`WR_CYCLES`.
- **How the bench keeps to this timing:** it drives strobes and samples outputs only on falling edges. Its driver pushes the expected column writes into a queue on the same falling edge that raises Stop. A monitor then pops one entry for every `mem_we` it sees, and the driver counts the falling edges at which `busy` is high and compares that count with `WR_CYCLES`.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_PROG   = 2'd2,
        ST_SETTLE = 2'd3
    } pgwr_state_e;

endpackage

// File: rtl/pgwr_addr_ptr.sv
module pgwr_addr_ptr #(
    parameter int ADDR_W = 11,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    localparam int PAGE_W = ADDR_W - COL_W;

    logic [PAGE_W-1:0] page_q;
    logic [COL_W-1:0]  col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            col_q  <= '0;
        end else if (load) begin
            page_q <= load_addr[ADDR_W-1:COL_W];
            col_q  <= load_addr[COL_W-1:0];
        end else if (step) begin
            col_q  <= col_q + 1'b1;
        end
    end

    assign ptr = {page_q, col_q};

    // R2
    page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (ptr[ADDR_W-1:COL_W] == $past(ptr[ADDR_W-1:COL_W])));

    // R3
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ptr[COL_W-1:0] == {COL_W{1'b1}}) |=> (ptr[COL_W-1:0] == '0));

endmodule

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    parameter int COL_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] slot_vld;

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_data[i] <= '0;
                slot_vld[i]  <= 1'b0;
            end else if (clr) begin
                slot_vld[i]  <= 1'b0;
            end else if (wr_en && wr_col == COL_W'(i)) begin
                slot_data[i] <= wr_data;
                slot_vld[i]  <= 1'b1;
            end
        end
    end

    assign rd_data   = slot_data[rd_col];
    assign rd_valid  = slot_vld[rd_col];
    assign any_valid = |slot_vld;

    // R9
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_valid);

    // R6
    write_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> any_valid);

endmodule

// File: rtl/pgwr_cycle_timer.sv
module pgwr_cycle_timer #(
    parameter int LIMIT = 40,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = run && (cnt == CNT_W'(LIMIT - 1));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(LIMIT - 1));

endmodule

// File: rtl/pgwr_sequencer.sv
module pgwr_sequencer
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              stop_stb,
    input  logic              abort_stb,
    input  logic              wp,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] ptr_addr
);
    localparam int COL_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    pgwr_state_e state_q, state_d;

    logic              acc_load, acc_byte, go_commit, drop, buf_clr;
    logic              run, tmr_last, prog_end;
    logic [CNT_W-1:0]  cnt;
    logic [COL_W-1:0]  rd_col;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid, any_valid;

    assign acc_load  = (state_q == ST_IDLE) && addr_load && !abort_stb;
    assign drop      = (state_q == ST_FILL) && abort_stb;
    assign acc_byte  = (state_q == ST_FILL) && byte_stb && !abort_stb && !stop_stb;
    assign go_commit = (state_q == ST_FILL) && stop_stb && !abort_stb && any_valid;
    assign run       = (state_q == ST_PROG) || (state_q == ST_SETTLE);
    assign prog_end  = (cnt == CNT_W'(PAGE_BYTES - 1));
    assign buf_clr   = acc_load || drop || ((state_q == ST_SETTLE) && tmr_last);
    assign rd_col    = cnt[COL_W-1:0];

    pgwr_addr_ptr #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (acc_load),
        .load_addr (addr_in),
        .step      (acc_byte),
        .ptr       (ptr_addr)
    );

    pgwr_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .COL_W(COL_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc_byte),
        .wr_col    (ptr_addr[COL_W-1:0]),
        .wr_data   (byte_in),
        .clr       (buf_clr),
        .rd_col    (rd_col),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    pgwr_cycle_timer #(.LIMIT(WR_CYCLES), .CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .cnt   (cnt),
        .last  (tmr_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_load) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (drop)                state_d = ST_IDLE;
                else if (go_commit)      state_d = ST_PROG;
                else if (stop_stb)       state_d = ST_IDLE;
            end
            ST_PROG: begin
                if (prog_end) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {ptr_addr[ADDR_W-1:COL_W], rd_col};
        mem_wdata = rd_data;
        unique case (state_q)
            ST_IDLE, ST_FILL: begin
                busy = 1'b0;
            end
            ST_PROG: begin
                busy   = 1'b1;
                mem_we = rd_valid && !wp;
            end
            ST_SETTLE: begin
                busy = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // R4
    start_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(state_q) == ST_FILL && $past(stop_stb)));

    // R6
    write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R6
    write_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1:COL_W] == ptr_addr[ADDR_W-1:COL_W]));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ptr_addr));

    // R8
    abort_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !busy);

endmodule

// File: tb/tb_pgwr_sequencer.sv
module tb_pgwr_sequencer;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int WRC = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0, byte_stb = 1'b0, stop_stb = 1'b0, abort_stb = 1'b0, wp = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] byte_in = '0;
    logic          busy, mem_we;
    logic [AW-1:0] mem_addr, ptr_addr;
    logic [DW-1:0] mem_wdata;

    always #5 clk = ~clk;

    pgwr_sequencer #(.WR_CYCLES(WRC)) dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .stop_stb(stop_stb),
        .abort_stb(abort_stb), .wp(wp), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ptr_addr(ptr_addr)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [AW+DW-1:0] exp_q[$];

    logic [DW-1:0] m_data [16];
    logic [15:0]   m_val = '0;
    logic [AW-1:0] m_ptr = '0;
    logic          m_fill = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: every array write must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4/R7/R8 unexpected write", int'({mem_addr, mem_wdata}), 0);
            end else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, "R6 write addr/data",
                      int'({mem_addr, mem_wdata}), int'(e));
            end
        end
    end

    task automatic do_load(input logic [AW-1:0] a);
        @(negedge clk);
        addr_load = 1'b1; addr_in = a;
        if (!m_fill) begin
            m_fill = 1'b1; m_ptr = a; m_val = '0;
        end
        @(negedge clk);
        addr_load = 1'b0;
        check(ptr_addr == m_ptr, "R2 pointer after load", int'(ptr_addr), int'(m_ptr));
    endtask

    task automatic do_byte(input logic [DW-1:0] d);
        @(negedge clk);
        byte_stb = 1'b1; byte_in = d;
        if (m_fill) begin
            m_data[m_ptr[3:0]] = d;
            m_val[m_ptr[3:0]]  = 1'b1;
            m_ptr = {m_ptr[AW-1:4], m_ptr[3:0] + 4'd1};
        end
        @(negedge clk);
        byte_stb = 1'b0;
    endtask

    task automatic do_abort();
        @(negedge clk);
        abort_stb = 1'b1;
        m_fill = 1'b0; m_val = '0;
        @(negedge clk);
        abort_stb = 1'b0;
        check(busy == 1'b0, "R8 no cycle after abort", int'(busy), 0);
    endtask

    task automatic do_stop(input bit poke_busy);
        bit exp_busy;
        int bc;
        @(negedge clk);
        exp_busy = m_fill && (m_val != '0);
        if (exp_busy && !wp) begin
            for (int k = 0; k < 16; k++)
                if (m_val[k]) exp_q.push_back({m_ptr[AW-1:4], 4'(k), m_data[k]});
        end
        m_fill = 1'b0;
        stop_stb = 1'b1;
        @(negedge clk);
        stop_stb = 1'b0;
        if (exp_busy) begin
            m_val = '0;
            bc = 0;
            while (busy && bc < 4 * WRC) begin
                bc++;
                if (poke_busy && bc == 20) begin
                    addr_load = 1'b1; addr_in = 11'h555;
                    byte_stb = 1'b1; byte_in = 8'hEE; stop_stb = 1'b1;
                end else begin
                    addr_load = 1'b0; byte_stb = 1'b0; stop_stb = 1'b0;
                end
                @(negedge clk);
            end
            addr_load = 1'b0; byte_stb = 1'b0; stop_stb = 1'b0;
            check(bc == WRC, "R5/R7 busy length", bc, WRC);
            @(negedge clk);
            check(busy == 1'b0, "R5 stays idle after cycle", int'(busy), 0);
        end else begin
            check(busy == 1'b0, "R4 no cycle without data", int'(busy), 0);
            @(negedge clk);
            check(busy == 1'b0, "R4 no cycle without data (2)", int'(busy), 0);
        end
        check(exp_q.size() == 0, "R6 all expected writes seen", exp_q.size(), 0);
        exp_q.delete();
        check(ptr_addr == m_ptr, "R9 pointer after cycle", int'(ptr_addr), int'(m_ptr));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        check(mem_we == 1'b0, "R1 mem_we in reset", int'(mem_we), 0);
        check(ptr_addr == '0, "R1 pointer in reset", int'(ptr_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: bytes with no address loaded are ignored
        do_byte(8'hAA);
        check(ptr_addr == '0, "R10 idle byte ignored", int'(ptr_addr), 0);
        do_stop(1'b0);

        // byte write (R2, R4, R5, R6, R9)
        do_load(11'h123);
        do_byte(8'h5A);
        check(ptr_addr == 11'h124, "R2 pointer step", int'(ptr_addr), 'h124);
        do_stop(1'b0);

        // page write with wrap (R2, R3, R6, R9)
        do_load(11'h7FD);
        for (int i = 0; i < 18; i++) begin
            do_byte(8'(i + 8'h10));
            if (i == 2)
                check(ptr_addr == 11'h7F0, "R2 upper bits fixed at column wrap",
                      int'(ptr_addr), 'h7F0);
        end
        check(ptr_addr == 11'h7FF, "R3 pointer after 18 bytes", int'(ptr_addr), 'h7FF);
        do_stop(1'b0);

        // sparse write after full page: only new slots written (R6, R9)
        do_load(11'h045);
        do_byte(8'hC1);
        do_byte(8'hC2);
        do_stop(1'b0);

        // address only, then Stop: no cycle (R4)
        do_load(11'h300);
        do_stop(1'b0);
        check(ptr_addr == 11'h300, "R4 pointer kept on address-only", int'(ptr_addr), 'h300);

        // abort discards data (R8)
        do_load(11'h210);
        do_byte(8'h01);
        do_byte(8'h02);
        do_byte(8'h03);
        do_abort();
        check(ptr_addr == 11'h213, "R8 pointer kept after abort", int'(ptr_addr), 'h213);
        do_stop(1'b0);

        // write protect: full-length cycle, no writes (R7)
        @(negedge clk);
        wp = 1'b1;
        do_load(11'h400);
        do_byte(8'h77);
        do_byte(8'h78);
        do_stop(1'b0);
        @(negedge clk);
        wp = 1'b0;

        // inputs during busy are ignored (R5)
        do_load(11'h6A0);
        do_byte(8'h3C);
        do_stop(1'b1);
        check(ptr_addr == 11'h6A1, "R5 pointer untouched by busy inputs", int'(ptr_addr), 'h6A1);
        do_stop(1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule